// File: doc/BRIEF.md
# Parallel Three-Error-Correcting BCH Check-Bit Encoder

This block turns a 5-bit data word into a 15-bit codeword of a binary BCH code with length 15, five data bits and minimum distance 7, so that a later decoder can locate and fix up to three flipped bits anywhere in the word. It is meant to sit beside a small arithmetic unit, for example a GF(2^5) multiplier, and to protect that unit's result word. The ten check bits and the assembled codeword come out together.

The code works over GF(2^4), built on the primitive polynomial x^4 + x + 1. The generator polynomial is the product of the distinct minimal polynomials of alpha, alpha^3 and alpha^5. The minimal polynomials of the even powers repeat those of the odd powers, so they add no factor. The result is g(x) = x^10 + x^8 + x^5 + x^4 + x^2 + x + 1. No serial division register is used. Each check bit is a fixed XOR tree over the data bits, and the tree's taps are derived at elaboration time from g(x). The block has no clock and holds no state, so every output follows the present data word in the same time step.

The block has no sequencer, so it has no states and no transitions.

Top module: `bch15_parity_enc`

## Requirements
- R1: The check bits follow these equations, where `parity_o[j]` is pj and `data_i[i]` is ci: p0=c0^c2^c4, p1=c0^c1^c2^c3^c4, p2=c0^c1^c3, p3=c1^c2^c4, p4=c0^c3^c4, p5=c0^c1^c2, p6=c1^c2^c3, p7=c2^c3^c4, p8=c0^c2^c3, p9=c1^c3^c4.
- R2: In `code_o`, bits 9..0 equal `parity_o[9:0]`, and data bit ci sits at bit 10+i (bits 14..10). The syndrome side relies on this position map.
- R3: Read `code_o[j]` as the coefficient of x^j. The codeword polynomial then leaves a zero remainder when divided by g(x) = x^10+x^8+x^5+x^4+x^2+x+1.
- R4: Any two codewords from different data words differ in at least 7 bit positions.
- R5: The all-zero data word gives an all-zero codeword.
- R6: The outputs depend only on the present data word. The same word gives the same codeword whatever words came before it.
- R7: The encoding is linear over GF(2): the codeword of a^b equals the codeword of a XOR the codeword of b.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| data_i | input | 5 | Data word c4..c0 to be protected |
| parity_o | output | 10 | Check bits p9..p0 |
| code_o | output | 15 | Assembled codeword, check bits low and data high |

## Verification
The bench applies all 32 data words. For each one it compares the check bits with the ten equations and re-divides the codeword by g(x) with its own long division. A tap derived from the wrong power of x, or a data bit placed at the wrong position, leaves a non-zero remainder or a wrong check bit. It then compares every pair of codewords for distance and linearity. A dropped or doubled tap pulls some pair below distance 7 or breaks the XOR relation. Finally it revisits one word after a different history, so that any hidden state or stale output shows up as a mismatch.

// File: rtl/bch15_pkg.sv
package bch15_pkg;

    localparam int BCH_N = 15;
    localparam int BCH_K = 5;
    localparam int BCH_P = BCH_N - BCH_K;

    // g(x) = x^10 + x^8 + x^5 + x^4 + x^2 + x + 1
    localparam logic [BCH_P:0] BCH_GEN = 11'h537;

    // x^e mod g(x), as a BCH_P-bit coefficient vector
    function automatic logic [BCH_P-1:0] xpow_rem(input int e);
        logic [BCH_P:0] r;
        r    = '0;
        r[0] = 1'b1;
        for (int s = 0; s < e; s++) begin
            r = {r[BCH_P-1:0], 1'b0};
            if (r[BCH_P]) begin
                r = r ^ BCH_GEN;
            end
        end
        return r[BCH_P-1:0];
    endfunction

    // remainder of a full codeword polynomial modulo g(x)
    function automatic logic [BCH_P-1:0] poly_rem(input logic [BCH_N-1:0] c);
        logic [BCH_P-1:0] acc;
        acc = '0;
        for (int i = 0; i < BCH_N; i++) begin
            if (c[i]) begin
                acc = acc ^ xpow_rem(i);
            end
        end
        return acc;
    endfunction

endpackage

// File: rtl/bch15_parity_row.sv
module bch15_parity_row #(
    parameter int DATA_W = bch15_pkg::BCH_K,
    parameter int CHK_W  = bch15_pkg::BCH_P,
    parameter int ROW    = 0
) (
    input  logic [DATA_W-1:0] data_i,
    output logic              bit_o
);
    // data bit i carries x^(CHK_W+i); row ROW taps it when that power mod g has term x^ROW
    function automatic logic [DATA_W-1:0] tap_mask();
        logic [DATA_W-1:0]           m;
        logic [bch15_pkg::BCH_P-1:0] col;
        m = '0;
        for (int i = 0; i < DATA_W; i++) begin
            col  = bch15_pkg::xpow_rem(CHK_W + i);
            m[i] = col[ROW];
        end
        return m;
    endfunction

    localparam logic [DATA_W-1:0] TAPS = tap_mask();

    always_comb begin
        bit_o = ^(data_i & TAPS);
    end
endmodule

// File: rtl/bch15_parity_net.sv
module bch15_parity_net #(
    parameter int DATA_W = bch15_pkg::BCH_K,
    parameter int CHK_W  = bch15_pkg::BCH_P
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  parity_o
);
    for (genvar j = 0; j < CHK_W; j++) begin : g_row
        bch15_parity_row #(
            .DATA_W (DATA_W),
            .CHK_W  (CHK_W),
            .ROW    (j)
        ) u_row (
            .data_i (data_i),
            .bit_o  (parity_o[j])
        );
    end
endmodule

// File: rtl/bch15_code_pack.sv
module bch15_code_pack #(
    parameter int DATA_W = bch15_pkg::BCH_K,
    parameter int CHK_W  = bch15_pkg::BCH_P,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    input  logic [CHK_W-1:0]  parity_i,
    output logic [CODE_W-1:0] code_o
);
    for (genvar i = 0; i < CODE_W; i++) begin : g_pos
        if (i < CHK_W) begin : g_chk
            assign code_o[i] = parity_i[i];
        end else begin : g_dat
            assign code_o[i] = data_i[i-CHK_W];
        end
    end
endmodule

// File: rtl/bch15_parity_enc.sv
module bch15_parity_enc #(
    parameter int DATA_W = bch15_pkg::BCH_K,
    parameter int CHK_W  = bch15_pkg::BCH_P,
    localparam int CODE_W = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CHK_W-1:0]  parity_o,
    output logic [CODE_W-1:0] code_o
);
    logic [CHK_W-1:0] chk_w;

    bch15_parity_net #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W)
    ) u_net (
        .data_i   (data_i),
        .parity_o (chk_w)
    );

    bch15_code_pack #(
        .DATA_W (DATA_W),
        .CHK_W  (CHK_W)
    ) u_pack (
        .data_i   (data_i),
        .parity_i (chk_w),
        .code_o   (code_o)
    );

    assign parity_o = chk_w;
endmodule

// File: rtl/bch15_enc_checker.sv
module bch15_enc_checker (
    input logic [4:0]  data_i,
    input logic [9:0]  parity_o,
    input logic [14:0] code_o
);
    logic [9:0] eqn_w;

    always_comb begin
        eqn_w[0] = data_i[0] ^ data_i[2] ^ data_i[4];
        eqn_w[1] = data_i[0] ^ data_i[1] ^ data_i[2] ^ data_i[3] ^ data_i[4];
        eqn_w[2] = data_i[0] ^ data_i[1] ^ data_i[3];
        eqn_w[3] = data_i[1] ^ data_i[2] ^ data_i[4];
        eqn_w[4] = data_i[0] ^ data_i[3] ^ data_i[4];
        eqn_w[5] = data_i[0] ^ data_i[1] ^ data_i[2];
        eqn_w[6] = data_i[1] ^ data_i[2] ^ data_i[3];
        eqn_w[7] = data_i[2] ^ data_i[3] ^ data_i[4];
        eqn_w[8] = data_i[0] ^ data_i[2] ^ data_i[3];
        eqn_w[9] = data_i[1] ^ data_i[3] ^ data_i[4];
    end

    always_comb begin
        AST_PARITY_EQN: assert (parity_o == eqn_w); // R1
        AST_CODE_LAYOUT: assert (code_o[14:10] == data_i && code_o[9:0] == parity_o); // R2
        AST_ZERO_REMAINDER: assert (bch15_pkg::poly_rem(code_o) == '0); // R3
        AST_MIN_WEIGHT: assert (data_i == '0 || $countones(code_o) >= 7); // R4
        AST_ZERO_WORD: assert (data_i != '0 || code_o == '0); // R5
    end
endmodule

bind bch15_parity_enc bch15_enc_checker u_chk (
    .data_i   (data_i),
    .parity_o (parity_o),
    .code_o   (code_o)
);

// File: tb/test_bch15_parity_enc.sv
module test_bch15_parity_enc;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 5000;
    localparam logic [10:0] GEN = 11'h537;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  data_i = '0;
    logic [9:0]  parity_o;
    logic [14:0] code_o;

    int checks = 0;
    int fails  = 0;
    logic [14:0] seen [32];

    always #(CLK_PERIOD/2) clk = ~clk;

    bch15_parity_enc i_bch15_parity_enc (
        .data_i   (data_i),
        .parity_o (parity_o),
        .code_o   (code_o)
    );

    function automatic logic [9:0] exp_parity(input logic [4:0] c);
        logic [9:0] p;
        p[0] = c[0] ^ c[2] ^ c[4];
        p[1] = c[0] ^ c[1] ^ c[2] ^ c[3] ^ c[4];
        p[2] = c[0] ^ c[1] ^ c[3];
        p[3] = c[1] ^ c[2] ^ c[4];
        p[4] = c[0] ^ c[3] ^ c[4];
        p[5] = c[0] ^ c[1] ^ c[2];
        p[6] = c[1] ^ c[2] ^ c[3];
        p[7] = c[2] ^ c[3] ^ c[4];
        p[8] = c[0] ^ c[2] ^ c[3];
        p[9] = c[1] ^ c[3] ^ c[4];
        return p;
    endfunction

    function automatic logic [9:0] long_div(input logic [14:0] c);
        logic [14:0] r;
        r = c;
        for (int b = 14; b >= 10; b--) begin
            if (r[b]) r = r ^ (15'(GEN) << (b - 10));
        end
        return r[9:0];
    endfunction

    task automatic check(input bit ok, input string req, input logic [14:0] act, input logic [14:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic apply(input logic [4:0] d);
        @(negedge clk);
        data_i = d;
        #(CLK_PERIOD/4);
    endtask

    initial begin : watchdog
        for (int n = 0; n < WATCHDOG; n++) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", WATCHDOG, 0);
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(5'd0);
        check(code_o == '0, "R5", code_o, 15'h0);

        for (int d = 0; d < 32; d++) begin
            apply(5'(d));
            seen[d] = code_o;
            check(parity_o == exp_parity(5'(d)), "R1", 15'(parity_o), 15'(exp_parity(5'(d))));
            check(code_o[14:10] == 5'(d) && code_o[9:0] == parity_o, "R2",
                  code_o, {5'(d), parity_o});
            check(long_div(code_o) == '0, "R3", 15'(long_div(code_o)), 15'h0);
        end

        for (int a = 0; a < 32; a++) begin
            for (int b = a + 1; b < 32; b++) begin
                check($countones(seen[a] ^ seen[b]) >= 7, "R4",
                      15'($countones(seen[a] ^ seen[b])), 15'd7);
            end
        end

        for (int a = 0; a < 32; a++) begin
            for (int b = 0; b < 32; b++) begin
                check((seen[a] ^ seen[b]) == seen[a ^ b], "R7", seen[a] ^ seen[b], seen[a ^ b]);
            end
        end

        apply(5'd31);
        apply(5'd0);
        apply(5'd5);
        check(code_o == seen[5], "R6", code_o, seen[5]);
        apply(5'd10);
        apply(5'd5);
        check(code_o == seen[5], "R6", code_o, seen[5]);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule